// File: doc/BRIEF.md
# Serial Frame Hunter and Byte Aligner

This block sits behind a serial receive front end. It takes one bit per clock
enable, shifts the bits into a window, and groups them eight at a time into
bytes with the most significant bit first. Each finished byte is driven on a
parallel output together with a one-cycle strobe.

When the out-of-frame control is high, the block searches every bit position
for the framing marker. The marker is three A1 bytes (`8'hF6`) followed at
once by three A2 bytes (`8'h28`). When it finds the marker, it moves its byte
boundary so that the last A2 comes out as a whole byte, and it raises a frame
flag for that one byte. It keeps searching for as long as the control stays
high, even after a frame has been found.

When the control is low, the block does not search, raises no frame flag, and
leaves the byte boundary where it last was. A receive framer upstream holds the
control high until it has confirmed frame alignment.

Top module: `sfa_framer`

## Requirements
- R1: The first bit accepted for a byte appears on `byte_o[7]` and the last bit on `byte_o[0]`.
- R2: Bits are accepted only on clock edges where `bit_en_i` is high. `byte_vld_o` is high for one cycle after the edge that accepts the eighth bit of a byte. On an edge where `bit_en_i` is low, `byte_vld_o` is low, and `byte_o` and `frame_o` keep their values.
- R3: While `rst_i` is high, `byte_vld_o`, `frame_o` and `byte_o` are zero. After reset, the first byte ends on the eighth accepted bit. Bits received before reset never take part in a match.
- R4: With `oof_i` high, the marker F6 F6 F6 28 28 28 is recognised at any bit offset in the stream. After the edge that accepts the last bit of the third 28, `byte_vld_o` is 1, `byte_o` is 8'h28 and `frame_o` is 1.
- R5: After a recognised marker, each following byte is made of the next eight bits after the third 28.
- R6: `frame_o` changes only on byte strobes. It stays high from the marker byte strobe until the next strobe and then falls, unless that next strobe also ends a marker.
- R7: While `oof_i` is low, no marker is recognised and `frame_o` stays low on every strobe. The byte boundary keeps its previous position.
- R8: While `oof_i` stays high, the search continues after a detection. A later marker at a new bit offset moves the boundary again and raises `frame_o` again.
- R9: A sequence that is not the full marker is not recognised. This covers two A1 bytes before the A2 bytes, only two A2 bytes, and a third A2 byte with one bit wrong.
- R10: A marker is caught when `oof_i` goes high 32 accepted bits (four bytes) before the point where the A1 bytes end and the A2 bytes begin, and stays high through the third A2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| bit_i | input | 1 | Serial data bit |
| bit_en_i | input | 1 | High when `bit_i` holds a new bit |
| oof_i | input | 1 | Out-of-frame level; enables the marker search |
| byte_o | output | 8 | Most recent assembled byte |
| byte_vld_o | output | 1 | One-cycle strobe for a new byte |
| frame_o | output | 1 | High for the byte period of the third A2 |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a marker of three A1 and three A2 bytes, and A1 = F6, A2 = 28. With a window this short, the bench can run all 256 byte values through the deserializer. It can also place the marker after every prefix length from 0 to 15 bits, which reaches every byte phase twice. Each of those runs also covers a second detection at a new offset, a marker ignored while the control is low, the four-byte early raise of the control, near-miss patterns, and a reset in the middle of a marker.

// File: rtl/sfa_pkg.sv
package sfa_pkg;

    // Width of one SONET/SDH byte on the parallel side.
    localparam int SFA_BYTE_W = 8;
    localparam int SFA_PH_W   = $clog2(SFA_BYTE_W);

    typedef logic [SFA_BYTE_W-1:0] sfa_byte_t;
    typedef logic [SFA_PH_W-1:0]   sfa_phase_t;

    // What the current accepted bit does to the byte assembly.
    typedef enum logic [1:0] {
        SFA_EV_NONE  = 2'd0,
        SFA_EV_BYTE  = 2'd1,
        SFA_EV_FRAME = 2'd2
    } sfa_event_e;

    // Registered output bundle of the aligner.
    typedef struct packed {
        logic      vld;
        logic      frame;
        sfa_byte_t data;
    } sfa_out_t;

    // Last phase value of a byte.
    function automatic sfa_phase_t sfa_last_phase();
        return sfa_phase_t'(SFA_BYTE_W - 1);
    endfunction

    // Marker byte expected at position k, where k = 0 is the most recent byte.
    function automatic sfa_byte_t sfa_marker_byte(
        input int        k,
        input int        n_second,
        input sfa_byte_t first_val,
        input sfa_byte_t second_val
    );
        return (k < n_second) ? second_val : first_val;
    endfunction

endpackage

// File: rtl/sfa_bit_window.sv
module sfa_bit_window
    import sfa_pkg::*;
#(
    parameter int DEPTH = 48
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             bit_i,
    input  logic             bit_en_i,
    output logic [DEPTH-1:0] win_next_o
);

    logic [DEPTH-1:0] win_q;

    // The window as it will be after this edge. The newest bit is at the LSB.
    assign win_next_o = {win_q[DEPTH-2:0], bit_i};

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            win_q <= '0;
        end else if (bit_en_i) begin
            win_q <= win_next_o;
        end
    end

endmodule

// File: rtl/sfa_marker_match.sv
module sfa_marker_match
    import sfa_pkg::*;
#(
    parameter int        N_FIRST    = 3,
    parameter int        N_SECOND   = 3,
    parameter sfa_byte_t FIRST_VAL  = 8'hF6,
    parameter sfa_byte_t SECOND_VAL = 8'h28,
    localparam int       N_BYTES    = N_FIRST + N_SECOND,
    localparam int       WIN_W      = N_BYTES * SFA_BYTE_W
) (
    input  logic [WIN_W-1:0] win_i,
    output logic             hit_o
);

    logic [N_BYTES-1:0] byte_ok;

    // One comparator per marker byte. The second-kind bytes are the newest.
    for (genvar k = 0; k < N_BYTES; k++) begin : g_cmp
        localparam sfa_byte_t EXP_BYTE =
            sfa_marker_byte(k, N_SECOND, FIRST_VAL, SECOND_VAL);
        assign byte_ok[k] = (win_i[k*SFA_BYTE_W +: SFA_BYTE_W] == EXP_BYTE);
    end

    assign hit_o = &byte_ok;

endmodule

// File: rtl/sfa_byte_phase.sv
module sfa_byte_phase
    import sfa_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      bit_en_i,
    input  logic      oof_i,
    input  logic      hit_i,
    input  sfa_byte_t cur_byte_i,
    output sfa_out_t  out_o
);

    sfa_phase_t ph_q;
    sfa_event_e ev;
    sfa_out_t   out_q;

    always_comb begin
        ev = SFA_EV_NONE;
        if (bit_en_i) begin
            if (oof_i && hit_i) begin
                ev = SFA_EV_FRAME;
            end else if (ph_q == sfa_last_phase()) begin
                ev = SFA_EV_BYTE;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ph_q  <= '0;
            out_q <= '0;
        end else begin
            out_q.vld <= 1'b0;
            unique case (ev)
                SFA_EV_FRAME: begin
                    ph_q        <= '0;
                    out_q.vld   <= 1'b1;
                    out_q.frame <= 1'b1;
                    out_q.data  <= cur_byte_i;
                end
                SFA_EV_BYTE: begin
                    ph_q        <= '0;
                    out_q.vld   <= 1'b1;
                    out_q.frame <= 1'b0;
                    out_q.data  <= cur_byte_i;
                end
                default: begin
                    if (bit_en_i) begin
                        ph_q <= ph_q + sfa_phase_t'(1);
                    end
                end
            endcase
        end
    end

    assign out_o = out_q;

endmodule

// File: rtl/sfa_framer.sv
module sfa_framer
    import sfa_pkg::*;
#(
    parameter int        N_A1   = 3,
    parameter int        N_A2   = 3,
    parameter sfa_byte_t A1     = 8'hF6,
    parameter sfa_byte_t A2     = 8'h28,
    localparam int       WIN_W  = (N_A1 + N_A2) * SFA_BYTE_W
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  bit_i,
    input  logic                  bit_en_i,
    input  logic                  oof_i,
    output logic [SFA_BYTE_W-1:0] byte_o,
    output logic                  byte_vld_o,
    output logic                  frame_o
);

    logic [WIN_W-1:0] win_next;
    logic             hit;
    sfa_out_t         out;

    sfa_bit_window #(
        .DEPTH (WIN_W)
    ) u_window (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .bit_i      (bit_i),
        .bit_en_i   (bit_en_i),
        .win_next_o (win_next)
    );

    sfa_marker_match #(
        .N_FIRST    (N_A1),
        .N_SECOND   (N_A2),
        .FIRST_VAL  (A1),
        .SECOND_VAL (A2)
    ) u_match (
        .win_i (win_next),
        .hit_o (hit)
    );

    sfa_byte_phase u_phase (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .bit_en_i   (bit_en_i),
        .oof_i      (oof_i),
        .hit_i      (hit),
        .cur_byte_i (win_next[SFA_BYTE_W-1:0]),
        .out_o      (out)
    );

    assign byte_o     = out.data;
    assign byte_vld_o = out.vld;
    assign frame_o    = out.frame;

endmodule

// File: rtl/sfa_framer_chk.sv
module sfa_framer_chk #(
    parameter logic [7:0] A2_VAL = 8'h28
) (
    input logic       clk_i,
    input logic       rst_i,
    input logic       bit_i,
    input logic       bit_en_i,
    input logic       oof_i,
    input logic [7:0] byte_o,
    input logic       byte_vld_o,
    input logic       frame_o
);

    p_frame_needs_oof_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (byte_vld_o && frame_o) |-> $past(oof_i));

    p_frame_byte_is_a2_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (byte_vld_o && frame_o) |-> (byte_o == A2_VAL));

    p_frame_held_between_strobes_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !byte_vld_o |-> $stable(frame_o));

    p_strobe_needs_bit_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        byte_vld_o |-> $past(bit_en_i));

    p_idle_keeps_byte_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(bit_en_i) |-> (!byte_vld_o && $stable(byte_o)));

    p_reset_clears_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (!byte_vld_o && !frame_o && byte_o == 8'h00));

endmodule

bind sfa_framer sfa_framer_chk #(.A2_VAL(A2)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .bit_i      (bit_i),
    .bit_en_i   (bit_en_i),
    .oof_i      (oof_i),
    .byte_o     (byte_o),
    .byte_vld_o (byte_vld_o),
    .frame_o    (frame_o)
);

// File: tb/sfa_framer_tb_top.sv
module sfa_framer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A1V = 8'hF6;
    localparam logic [7:0] A2V = 8'h28;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_i = 1'b0;
    logic       bit_en = 1'b0;
    logic       oof = 1'b0;
    logic [7:0] byte_o;
    logic       byte_vld_o;
    logic       frame_o;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    // Bench-side expectation derived from the requirements.
    logic [7:0] hist = 8'h00;
    int         ph = 0;
    logic [7:0] exp_byte = 8'h00;
    logic       exp_frame = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sfa_framer dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .bit_i      (bit_i),
        .bit_en_i   (bit_en),
        .oof_i      (oof),
        .byte_o     (byte_o),
        .byte_vld_o (byte_vld_o),
        .frame_o    (frame_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic send_bit(input logic b, input logic det, input string req);
        logic exp_vld;
        @(negedge clk);
        bit_i  = b;
        bit_en = 1'b1;
        @(posedge clk);
        #1;
        bit_en = 1'b0;
        hist = {hist[6:0], b};
        exp_vld = det || (ph == 7);
        if (exp_vld) begin
            exp_byte  = hist;
            exp_frame = det;
            ph = 0;
        end else begin
            ph = ph + 1;
        end
        chk({req, " strobe"}, 32'(byte_vld_o), 32'(exp_vld));
        chk({req, " byte"},   32'(byte_o),     32'(exp_byte));
        chk({req, " frame"},  32'(frame_o),    32'(exp_frame));
    endtask

    task automatic send_byte(input logic [7:0] v, input logic det_last, input string req);
        for (int i = 7; i >= 0; i--) begin
            send_bit(v[i], det_last && (i == 0), req);
        end
    endtask

    task automatic send_zeros(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            send_bit(1'b0, 1'b0, req);
        end
    endtask

    task automatic send_marker(input logic det, input string req);
        for (int k = 0; k < 3; k++) send_byte(A1V, 1'b0, req);
        send_byte(A2V, 1'b0, req);
        send_byte(A2V, 1'b0, req);
        send_byte(A2V, det, req);
    endtask

    // R2: an edge without bit_en changes nothing at the outputs.
    task automatic idle_cycle();
        @(negedge clk);
        bit_en = 1'b0;
        bit_i  = ~bit_i;
        @(posedge clk);
        #1;
        chk("R2 idle strobe", 32'(byte_vld_o), 32'd0);
        chk("R2 idle byte",   32'(byte_o),     32'(exp_byte));
        chk("R2 idle frame",  32'(frame_o),    32'(exp_frame));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst    = 1'b1;
        bit_en = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R3 reset strobe", 32'(byte_vld_o), 32'd0);
        chk("R3 reset frame",  32'(frame_o),    32'd0);
        chk("R3 reset byte",   32'(byte_o),     32'd0);
        @(negedge clk);
        rst = 1'b0;
        hist = 8'h00;
        ph = 0;
        exp_byte = 8'h00;
        exp_frame = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual running expected finished");
            finish_run();
        end
    end

    initial begin
        // R1: every byte value with the search disabled.
        do_reset();
        oof = 1'b0;
        for (int v = 0; v < 256; v++) begin
            send_byte(8'(v), 1'b0, "R1");
            chk("R1 msb first", 32'(byte_o), 32'(v));
            if (v % 16 == 0) idle_cycle();
        end

        // Marker at every prefix length 0..15.
        for (int p = 0; p < 16; p++) begin
            do_reset();
            // R10: raise oof exactly 32 bits before the A1/A2 boundary when possible.
            oof = (p < 8);
            for (int i = 0; i < p; i++) begin
                if (i == p - 8) oof = 1'b1;
                send_bit(1'b0, 1'b0, "R10 prefix");
            end
            send_marker(1'b1, "R4");
            chk("R4 frame on third A2", 32'(frame_o), 32'd1);
            chk("R4 byte is A2",        32'(byte_o),  32'(A2V));
            chk("R10 caught after early oof", 32'(byte_vld_o), 32'd1);
            idle_cycle();
            for (int i = 7; i >= 1; i--) begin
                send_bit(((8'hA5 >> i) & 8'h01) != 0, 1'b0, "R6");
                chk("R6 frame held", 32'(frame_o), 32'd1);
            end
            send_bit(1'b1, 1'b0, "R5");
            chk("R5 realigned byte", 32'(byte_o),  32'hA5);
            chk("R6 frame dropped",  32'(frame_o), 32'd0);

            // R8: a second marker at a shifted offset while oof stays high.
            send_zeros(3 + (p % 5), "R8 gap");
            send_marker(1'b1, "R8");
            chk("R8 second frame", 32'(frame_o), 32'd1);
            send_byte(8'h3C, 1'b0, "R8");
            chk("R8 realigned", 32'(byte_o), 32'h3C);

            // R7: oof low, marker ignored, alignment kept.
            oof = 1'b0;
            send_zeros(5, "R7 gap");
            send_marker(1'b0, "R7");
            send_zeros(16, "R7 tail");
            chk("R7 no frame", 32'(frame_o), 32'd0);
        end

        // R9: near misses with oof high.
        do_reset();
        oof = 1'b1;
        send_byte(A1V, 1'b0, "R9");
        send_byte(A1V, 1'b0, "R9");
        send_byte(A2V, 1'b0, "R9");
        send_byte(A2V, 1'b0, "R9");
        send_byte(A2V, 1'b0, "R9");
        for (int k = 0; k < 3; k++) send_byte(A1V, 1'b0, "R9");
        send_byte(A2V, 1'b0, "R9");
        send_byte(A2V, 1'b0, "R9");
        send_byte(8'h00, 1'b0, "R9");
        for (int k = 0; k < 3; k++) send_byte(A1V, 1'b0, "R9");
        send_byte(A2V, 1'b0, "R9");
        send_byte(A2V, 1'b0, "R9");
        send_byte(8'h29, 1'b0, "R9");
        chk("R9 no frame", 32'(frame_o), 32'd0);

        // R3: reset in the middle of a marker clears the window.
        do_reset();
        oof = 1'b1;
        for (int k = 0; k < 3; k++) send_byte(A1V, 1'b0, "R3 pre");
        send_byte(A2V, 1'b0, "R3 pre");
        send_byte(A2V, 1'b0, "R3 pre");
        for (int i = 7; i >= 1; i--) send_bit(A2V[i], 1'b0, "R3 pre");
        do_reset();
        send_bit(A2V[0], 1'b0, "R3 post");
        send_zeros(7, "R3 post");
        chk("R3 first byte after reset", 32'(byte_vld_o), 32'd1);
        chk("R3 no stale match",         32'(frame_o),    32'd0);

        done = 1'b1;
        finish_run();
    end

endmodule